// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Array with Pin Feedback

This block is a programmable AND array that feeds a fixed OR array. Ten primary inputs and six fed-back output pins reach the AND array, each in true and complement form. Each of the eight outputs owns seven product terms, and those terms feed only that output's OR gate. The output drives the inverse of that sum. An eighth term per output sets the output's three-state enable.

Configuration is written one term at a time through a clocked programming port. Evaluation from the inputs to the outputs is combinational. Outputs one to six are fed back into the array, so one output can act as a helper term for another and logic can be built in two or more passes. When one of those outputs is disabled, its fed-back value is taken from an external pin-input port. The configuration must contain no combinational loop through the feedback paths. The block resolves a loop-free chain of any depth up to the number of fed-back pins.

Top module: `fixed_or_array`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every stored term to all zeros. With no terms programmed, every output is enabled (out_oe all ones) and driven low (out_q all zeros).
- R2: With prog_we high at a rising clock edge, prog_data is stored as term prog_addr[2:0] of output prog_addr[5:3]. Term numbers 0 to 6 are sum terms and term 7 is the enable term. The new term acts on the outputs right after that edge.
- R3: In a term word, bit 2k selects the true form of signal k and bit 2k+1 selects its complement. Signals 0 to 9 are pal_in[0] to pal_in[9]. Signals 10 to 15 are the fed-back values of outputs 1 to 6.
- R4: A term is the AND of the literals it selects. A term that selects no literals is 1. A term that selects both forms of one signal is 0.
- R5: out_q[o] is the inverse of the OR of output o's seven sum terms.
- R6: out_oe[o] equals output o's enable term, so an empty enable term keeps the output enabled.
- R7: The fed-back value of an enabled output is its own out_q. The fed-back value of a disabled output is pin_in[j], where j is the output number minus 1.
- R8: A change on pin_in bits whose outputs are enabled has no effect on out_q or out_oe.
- R9: A loop-free chain of helper terms through all six fed-back outputs settles to its final value with no clock.
- R10: With prog_we low, prog_addr and prog_data have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the programming port |
| rst_n | input | 1 | Active-low synchronous reset; clears the configuration |
| prog_we | input | 1 | Term write strobe |
| prog_addr | input | 6 | Output number (bits 5:3) and term number (bits 2:0) |
| prog_data | input | 32 | Literal select word for one term |
| pal_in | input | 10 | Primary array inputs |
| pin_in | input | 6 | External values of outputs 1 to 6, used when those outputs are disabled |
| out_q | output | 8 | Inverted sum of products per output |
| out_oe | output | 8 | Output enable per output |

## Verification
Output 0 is tried over all eight combinations of a three-input function made of one two-literal term and one complemented single literal. This separates the literal polarity, the AND within a term, the OR between terms and the output inversion. An enable term driven by one input is toggled both ways. A helper-term pair is then run with the source output enabled and then disabled, while pin_in is toggled, which tells the internal feedback apart from the external pin value. A six-deep feedback chain, and port activity with the write strobe low, cover settling and write gating.

// File: rtl/fixed_or_array.sv
module fixed_or_array #(
  parameter int N_IN    = 10,
  parameter int N_OUT   = 8,
  parameter int N_FB    = 6,
  parameter int FB_LO   = 1,
  parameter int N_TERMS = 7
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       prog_we,
  input  logic [$clog2(N_OUT*(N_TERMS+1))-1:0]       prog_addr,
  input  logic [2*(N_IN+N_FB)-1:0]                   prog_data,
  input  logic [N_IN-1:0]                            pal_in,
  input  logic [N_FB-1:0]                            pin_in,
  output logic [N_OUT-1:0]                           out_q,
  output logic [N_OUT-1:0]                           out_oe
);
  localparam int N_SIG = N_IN + N_FB;
  localparam int LW    = 2 * N_SIG;
  localparam int TPO   = N_TERMS + 1;
  localparam int AW    = $clog2(N_OUT * TPO);
  localparam int DEPTH = 2 ** AW;

  logic [LW-1:0] cfg [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) cfg[a] <= '0;
    end else if (prog_we) begin
      cfg[prog_addr] <= prog_data;
    end
  end

  function automatic logic term_hit(input logic [LW-1:0] w, input logic [N_SIG-1:0] s);
    logic [LW-1:0] lit;
    for (int k = 0; k < N_SIG; k++) begin
      lit[2*k]   = s[k];
      lit[2*k+1] = ~s[k];
    end
    return &(lit | ~w);
  endfunction

  always_comb begin
    logic [N_FB-1:0]  fb;
    logic [N_OUT-1:0] q;
    logic [N_OUT-1:0] oe;
    logic             sum;
    fb  = pin_in;
    q   = '0;
    oe  = '0;
    sum = 1'b0;
    for (int p = 0; p <= N_FB; p++) begin
      for (int o = 0; o < N_OUT; o++) begin
        sum = 1'b0;
        for (int t = 0; t < N_TERMS; t++)
          sum = sum | term_hit(cfg[o*TPO+t], {fb, pal_in});
        q[o]  = ~sum;
        oe[o] = term_hit(cfg[o*TPO+N_TERMS], {fb, pal_in});
      end
      for (int j = 0; j < N_FB; j++)
        fb[j] = oe[FB_LO+j] ? q[FB_LO+j] : pin_in[j];
    end
    out_q  = q;
    out_oe = oe;
  end
endmodule

// File: rtl/fixed_or_array_chk.sv
module fixed_or_array_chk #(
  parameter int N_IN    = 10,
  parameter int N_OUT   = 8,
  parameter int N_FB    = 6,
  parameter int FB_LO   = 1,
  parameter int N_TERMS = 7
) (
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 prog_we,
  input logic [$clog2(N_OUT*(N_TERMS+1))-1:0] prog_addr,
  input logic [2*(N_IN+N_FB)-1:0]             prog_data,
  input logic [N_IN-1:0]                      pal_in,
  input logic [N_FB-1:0]                      pin_in,
  input logic [N_OUT-1:0]                     out_q,
  input logic [N_OUT-1:0]                     out_oe
);
  logic seen = 1'b0;
  logic wrote = 1'b0;
  logic was_rst = 1'b0;

  always_ff @(posedge clk) begin
    was_rst <= !rst_n;
    if (!rst_n) begin
      seen  <= 1'b0;
      wrote <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (prog_we) wrote <= 1'b1;
    end
  end

  assert_cleared_by_reset_R1: assert property (@(posedge clk)
    was_rst |-> (out_oe == '1 && out_q == '0));

  assert_blank_until_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote |-> (out_oe == '1 && out_q == '0));

  assert_hold_without_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(prog_we) && $stable(pal_in) && $stable(pin_in))
      |-> ($stable(out_q) && $stable(out_oe)));

  assert_enabled_pin_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(prog_we) && $stable(pal_in) && out_oe == '1 && $past(out_oe) == '1)
      |-> $stable(out_q));
endmodule

bind fixed_or_array fixed_or_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .N_FB(N_FB), .FB_LO(FB_LO), .N_TERMS(N_TERMS)
) u_chk (.*);

// File: tb/fixed_or_array_bench.sv
module fixed_or_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [9:0]  pal_in = '0;
  logic [5:0]  pin_in = '0;
  logic [7:0]  out_q, out_oe;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [31:0] NEVER = 32'h3;

  always #10 clk = ~clk;

  fixed_or_array u_fixed_or_array (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .pal_in(pal_in), .pin_in(pin_in),
    .out_q(out_q), .out_oe(out_oe)
  );

  function automatic logic [31:0] tru(input int k);
    return 32'h1 << (2*k);
  endfunction
  function automatic logic [31:0] cmp(input int k);
    return 32'h2 << (2*k);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int o, input int t, input logic [31:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 6'(o*8 + t); prog_data = d;
    @(negedge clk);
    prog_we = 1'b0;
    #2;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    settle();
    chk("R1 oe after reset", out_oe, 8'hff);
    chk("R1 q after reset", out_q, 8'h00);
  endtask

  task automatic t_clear_sums();
    for (int o = 0; o < 8; o++)
      for (int t = 0; t < 7; t++) wr(o, t, NEVER);
    chk("R4 contradictory terms give high outputs", out_q, 8'hff);
    chk("R6 empty enable terms keep outputs on", out_oe, 8'hff);
  endtask

  task automatic t_sop();
    wr(0, 0, tru(0) | tru(1));
    wr(0, 1, cmp(2));
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      logic e;
      b = 3'(v);
      pal_in[2:0] = b;
      settle();
      e = ~((b[0] & b[1]) | ~b[2]);
      chk("R3 R5 sum of products on output 0", {7'd0, out_q[0]}, {7'd0, e});
    end
  endtask

  task automatic t_enable();
    wr(7, 7, tru(9));
    pal_in[9] = 1'b0; settle();
    chk("R6 enable term false", {7'd0, out_oe[7]}, 8'd0);
    pal_in[9] = 1'b1; settle();
    chk("R6 enable term true", {7'd0, out_oe[7]}, 8'd1);
    chk("R2 term 7 does not touch the sum", {7'd0, out_q[7]}, 8'd1);
  endtask

  task automatic t_feedback();
    wr(1, 0, tru(3));
    wr(2, 0, tru(10));
    pal_in[3] = 1'b1; pin_in = 6'h00; settle();
    chk("R7 enabled feedback uses drive", {6'd0, out_q[2:1]}, 8'b10);
    pin_in = 6'h3f; settle();
    chk("R8 pin ignored while enabled", {6'd0, out_q[2:1]}, 8'b10);
    wr(1, 7, tru(8));
    pal_in[8] = 1'b0; pin_in = 6'h00; settle();
    chk("R7 disabled output off", {7'd0, out_oe[1]}, 8'd0);
    chk("R7 disabled feedback uses pin low", {7'd0, out_q[2]}, 8'd1);
    pin_in[0] = 1'b1; settle();
    chk("R7 disabled feedback uses pin high", {7'd0, out_q[2]}, 8'd0);
  endtask

  task automatic t_chain();
    wr(1, 7, 32'h0);
    wr(3, 0, tru(11));
    wr(4, 0, tru(12));
    wr(5, 0, tru(13));
    wr(6, 0, tru(14));
    pin_in = 6'h15;
    for (int v = 0; v < 2; v++) begin
      logic a;
      a = 1'(v);
      pal_in[3] = a; settle();
      chk("R9 six-deep helper chain", {1'b0, out_q[6:1]},
          {1'b0, a, ~a, a, ~a, a, ~a});
    end
  endtask

  task automatic t_gated();
    logic [7:0] q0, e0;
    q0 = out_q; e0 = out_oe;
    @(negedge clk);
    prog_addr = 6'(0*8 + 0); prog_data = 32'h0;
    @(negedge clk);
    prog_addr = 6'(7*8 + 7); prog_data = NEVER;
    @(negedge clk);
    #2;
    chk("R10 q unchanged without write strobe", out_q, q0);
    chk("R10 oe unchanged without write strobe", out_oe, e0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clear_sums();
    t_sop();
    t_enable();
    t_feedback();
    t_chain();
    t_gated();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule